// File: doc/BRIEF.md
# Sensing Power Mode Sequencer

This block paces the conversion cycles of a capacitive sensing front end and chooses which sense channels take part in each one. It counts a one-millisecond tick and emits a single-cycle start strobe together with a channel enable mask. The two outputs change in the same cycle, so the consumer can latch the mask on the strobe.

By default it runs at a fixed normal interval. A configuration bit switches it to a slower low-power interval, chosen from four settings. In low-power mode a proximity report pulls the rate back to the normal interval, and a hold timer keeps it there until a set time after the last report. When the extra-low-power option is enabled and no proximity has been seen for a long idle window, only the proximity channel stays in the mask. A full-mask conversion is still forced once per refresh window so that the other channels keep their baselines current. A rising edge of the sleep bit stops all conversions. A rising edge on the ready-line sample wakes the block again.

Top module: `sense_rate_seq`

## Requirements
- R1: After reset `conv_start` is 0 and `ch_en` has every bit set, and the block is awake in normal mode.
- R2: With `cfg_lp_en` = 0, consecutive `conv_start` pulses are exactly `NORM_MS` ticks apart.
- R3: With `cfg_lp_en` = 1 and no zoom hold active, the spacing is `LP_BASE_MS << cfg_lp_sel` ticks (sel 0,1,2,3 gives 32, 64, 128, 256 ms by default).
- R4: In low-power mode, a `prox_flag` pulse switches the spacing to `NORM_MS`. That spacing holds until `ZOOM_HOLD_MS` ticks have passed since the most recent pulse, and each new pulse restarts the hold.
- R5: With `cfg_xlp_en` = 1, once `IDLE_MS` ticks pass without `prox_flag`, conversions use a mask with only bit `PROX_CH` set (0x80 by default). Every mask that goes with a strobe is either that value or all ones.
- R6: In that reduced state, one conversion in each `REFRESH_MS`-tick window carries the all-ones mask. All other conversions carry the reduced mask.
- R7: A `prox_flag` pulse leaves the reduced state. The next conversion and those that follow carry the all-ones mask.
- R8: A rising edge of `cfg_sleep` puts the block to sleep. While asleep, no `conv_start` occurs and `ch_en` is 0.
- R9: While asleep, a rising edge of `rdy_line` wakes the block. The first strobe follows one full period later, and the block stays awake while `cfg_sleep` remains high. Edges on `rdy_line` while awake leave the period unchanged.
- R10: `conv_start` is only raised in the cycle after a cycle in which `tick_ms` was high, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| cfg_lp_en | input | 1 | Select the low-power interval |
| cfg_lp_sel | input | 2 | Low-power interval select |
| cfg_xlp_en | input | 1 | Allow fallback to proximity-channel-only operation |
| cfg_sleep | input | 1 | Rising edge enters sleep |
| prox_flag | input | 1 | Proximity detected on the proximity channel |
| rdy_line | input | 1 | Synchronised sample of the ready line |
| conv_start | output | 1 | One-cycle conversion start strobe |
| ch_en | output | NUM_CH | Channel enable mask for the current conversion |

## Verification
The assertions assume that `tick_ms` is a single-cycle pulse and that `rdy_line`, `prox_flag` and the configuration bits are already synchronous to `clk`. They also assume that `cfg_sleep` and `rdy_line` do not rise in the same cycle. The stimulus raises the tick every second cycle from a clocked process, so ticks are never back to back. All other inputs change on the falling edge, one at a time, and the ready line is only raised after sleep has been entered.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic {SR_AWAKE = 1'b0, SR_ASLEEP = 1'b1} sr_state_e;
endpackage

// File: rtl/sr_tick_timer.sv
// Tick-driven counter. Non-wrapping variant: hit is high while the count
// has reached LIMIT (saturating). Wrapping variant: hit pulses once per
// LIMIT ticks.
module sr_tick_timer #(
  parameter int LIMIT     = 3000,
  parameter bit WRAP      = 1'b0,
  parameter bit INIT_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM  = W'(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  generate
    if (WRAP) begin : g_wrap
      logic pulse_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt     <= '0;
          pulse_q <= 1'b0;
        end else begin
          pulse_q <= 1'b0;
          if (restart) begin
            cnt <= '0;
          end else if (run && tick) begin
            if (cnt == LAST) begin
              cnt     <= '0;
              pulse_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      end
      assign hit = pulse_q;
    end else begin : g_sat
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= INIT_FULL ? LIM : '0;
        end else if (restart) begin
          cnt <= '0;
        end else if (run && tick && (cnt != LIM)) begin
          cnt <= cnt + 1'b1;
        end
      end
      assign hit = (cnt == LIM);
    end
  endgenerate
endmodule

// File: rtl/sr_period_gen.sv
// Conversion pacing: fires on the tick that completes the current period.
module sr_period_gen #(
  parameter int NORM_MS    = 20,
  parameter int LP_BASE_MS = 32,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic             use_lp,
  input  logic [SEL_W-1:0] lp_sel,
  output logic             fire
);
  localparam int N_SEL  = 1 << SEL_W;
  localparam int LP_MAX = LP_BASE_MS << (N_SEL - 1);
  localparam int MAX_P  = (LP_MAX > NORM_MS) ? LP_MAX : NORM_MS;
  localparam int PW     = $clog2(MAX_P + 1);

  logic [PW-1:0] lp_tab [N_SEL];
  logic [PW-1:0] period;
  logic [PW-1:0] cnt;
  logic [PW-1:0] cnt_nxt;
  logic          done;

  generate
    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
      assign lp_tab[g] = PW'(LP_BASE_MS << g);
    end
  endgenerate

  assign period  = use_lp ? lp_tab[lp_sel] : PW'(NORM_MS);
  assign cnt_nxt = cnt + 1'b1;
  assign done    = (cnt_nxt >= period);
  assign fire    = run && tick && done;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= done ? '0 : cnt_nxt;
    end
  end
endmodule

// File: rtl/sr_mask_gen.sv
// Channel mask: every channel, or only the proximity channel.
module sr_mask_gen #(
  parameter int NUM_CH  = 8,
  parameter int PROX_CH = 7
) (
  input  logic              prox_only,
  output logic [NUM_CH-1:0] mask
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (c == PROX_CH) begin : g_keep
        assign mask[c] = 1'b1;
      end else begin : g_drop
        assign mask[c] = ~prox_only;
      end
    end
  endgenerate
endmodule

// File: rtl/sense_rate_seq.sv
module sense_rate_seq
  import sr_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int PROX_CH      = 7,
  parameter int NORM_MS      = 20,
  parameter int LP_BASE_MS   = 32,
  parameter int ZOOM_HOLD_MS = 3000,
  parameter int IDLE_MS      = 50000,
  parameter int REFRESH_MS   = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              cfg_lp_en,
  input  logic [1:0]        cfg_lp_sel,
  input  logic              cfg_xlp_en,
  input  logic              cfg_sleep,
  input  logic              prox_flag,
  input  logic              rdy_line,
  output logic              conv_start,
  output logic [NUM_CH-1:0] ch_en
);
  sr_state_e         state;
  logic              asleep;
  logic              awake;
  logic              sleep_prev;
  logic              rdy_prev;
  logic              sleep_rise;
  logic              rdy_rise;
  logic              wake_evt;
  logic              zoom_idle;
  logic              idle_full;
  logic              reduced;
  logic              refresh_hit;
  logic              refresh_pend;
  logic              use_lp;
  logic              fire;
  logic              mask_reduced;
  logic [NUM_CH-1:0] mask;

  assign asleep     = (state == SR_ASLEEP);
  assign awake      = ~asleep;
  assign sleep_rise = cfg_sleep & ~sleep_prev;
  assign rdy_rise   = rdy_line & ~rdy_prev;
  assign wake_evt   = asleep & rdy_rise;

  // Zoom hold: full (not zoomed) out of reset, cleared by proximity.
  sr_tick_timer #(.LIMIT(ZOOM_HOLD_MS), .WRAP(1'b0), .INIT_FULL(1'b1)) u_zoom (
    .clk(clk), .rst(rst), .tick(tick_ms), .run(awake),
    .restart(prox_flag), .hit(zoom_idle)
  );

  // Idle window without proximity.
  sr_tick_timer #(.LIMIT(IDLE_MS), .WRAP(1'b0), .INIT_FULL(1'b0)) u_idle (
    .clk(clk), .rst(rst), .tick(tick_ms), .run(awake),
    .restart(prox_flag), .hit(idle_full)
  );

  assign reduced = cfg_xlp_en & idle_full;

  // Refresh window inside the reduced state.
  sr_tick_timer #(.LIMIT(REFRESH_MS), .WRAP(1'b1), .INIT_FULL(1'b0)) u_refresh (
    .clk(clk), .rst(rst), .tick(tick_ms), .run(awake & reduced),
    .restart(~reduced), .hit(refresh_hit)
  );

  assign use_lp = cfg_lp_en & zoom_idle;

  sr_period_gen #(.NORM_MS(NORM_MS), .LP_BASE_MS(LP_BASE_MS), .SEL_W(2)) u_period (
    .clk(clk), .rst(rst), .tick(tick_ms),
    .run(awake & ~sleep_rise),
    .restart(wake_evt | sleep_rise),
    .use_lp(use_lp), .lp_sel(cfg_lp_sel), .fire(fire)
  );

  assign mask_reduced = reduced & ~prox_flag & ~refresh_pend;

  sr_mask_gen #(.NUM_CH(NUM_CH), .PROX_CH(PROX_CH)) u_mask (
    .prox_only(mask_reduced), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SR_AWAKE;
      sleep_prev   <= 1'b0;
      rdy_prev     <= 1'b1;
      refresh_pend <= 1'b0;
      conv_start   <= 1'b0;
      ch_en        <= '1;
    end else begin
      sleep_prev <= cfg_sleep;
      rdy_prev   <= rdy_line;
      conv_start <= fire;

      case (state)
        SR_AWAKE:  if (sleep_rise) state <= SR_ASLEEP;
        SR_ASLEEP: if (rdy_rise)   state <= SR_AWAKE;
        default:   state <= SR_AWAKE;
      endcase

      if (awake && sleep_rise) begin
        ch_en <= '0;
      end else if (fire) begin
        ch_en <= mask;
      end

      if (!reduced) begin
        refresh_pend <= 1'b0;
      end else if (refresh_hit) begin
        refresh_pend <= 1'b1;
      end else if (fire) begin
        refresh_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sr_seq_chk.sv
module sr_seq_chk #(
  parameter int NUM_CH  = 8,
  parameter int PROX_CH = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_ms,
  input logic              rdy_line,
  input logic              asleep,
  input logic              conv_start,
  input logic [NUM_CH-1:0] ch_en
);
  localparam logic [NUM_CH-1:0] ALL_ON    = '1;
  localparam logic [NUM_CH-1:0] PROX_ONLY = {{(NUM_CH-1){1'b0}}, 1'b1} << PROX_CH;

  // R10
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(tick_ms));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> !conv_start);

  // R8
  sleep_mask_off_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (ch_en == '0));

  // R9
  ready_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (asleep && rdy_line && !$past(rdy_line)) |=> !asleep);

  // R5
  mask_legal_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ((ch_en == ALL_ON) || (ch_en == PROX_ONLY)));
endmodule

bind sense_rate_seq sr_seq_chk #(.NUM_CH(NUM_CH), .PROX_CH(PROX_CH)) u_sr_chk (
  .clk(clk), .rst(rst), .tick_ms(tick_ms), .rdy_line(rdy_line),
  .asleep(asleep), .conv_start(conv_start), .ch_en(ch_en)
);

// File: tb/sense_rate_seq_bench.sv
module sense_rate_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 8;

  typedef struct packed {
    logic        lp;
    logic [1:0]  sel;
    int unsigned exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{lp: 1'b0, sel: 2'd0, exp: 4},
    '{lp: 1'b1, sel: 2'd0, exp: 8},
    '{lp: 1'b1, sel: 2'd1, exp: 16},
    '{lp: 1'b1, sel: 2'd2, exp: 32},
    '{lp: 1'b1, sel: 2'd3, exp: 64},
    '{lp: 1'b0, sel: 2'd3, exp: 4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic cfg_lp_en = 1'b0;
  logic [1:0] cfg_lp_sel = 2'd0;
  logic cfg_xlp_en = 1'b0;
  logic cfg_sleep = 1'b0;
  logic prox_flag = 1'b0;
  logic rdy_line = 1'b0;
  logic conv_start;
  logic [NCH-1:0] ch_en;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) tick_ms <= rst ? 1'b0 : ~tick_ms;

  sense_rate_seq #(
    .NUM_CH(NCH), .PROX_CH(7), .NORM_MS(4), .LP_BASE_MS(8),
    .ZOOM_HOLD_MS(40), .IDLE_MS(100), .REFRESH_MS(24)
  ) u_sense_rate_seq (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .cfg_lp_en(cfg_lp_en),
    .cfg_lp_sel(cfg_lp_sel), .cfg_xlp_en(cfg_xlp_en), .cfg_sleep(cfg_sleep),
    .prox_flag(prox_flag), .rdy_line(rdy_line),
    .conv_start(conv_start), .ch_en(ch_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (conv_start) break;
    end
  endtask

  task automatic count_to_strobe(output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (conv_start) break;
      if (tick_ms) n++;
    end
  endtask

  task automatic measure(output int n);
    wait_strobe();
    count_to_strobe(n);
  endtask

  task automatic wait_ticks(input int t);
    repeat (2 * t) @(negedge clk);
  endtask

  task automatic pulse_prox();
    @(negedge clk);
    prox_flag = 1'b1;
    @(negedge clk);
    prox_flag = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      finish_run();
    end
  end

  initial begin
    int n;
    int n_full;
    int n_red;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 conv_start after reset", conv_start, 0);
    check("R1 ch_en after reset", ch_en, 8'hFF);

    // Table walk: R2 normal spacing, R3 low-power spacing
    foreach (VECS[k]) begin
      cfg_lp_en  = VECS[k].lp;
      cfg_lp_sel = VECS[k].sel;
      wait_strobe();
      measure(n);
      check(VECS[k].lp ? "R3 lp period" : "R2 normal period", n, int'(VECS[k].exp));
    end

    // R10 strobe lasts one cycle
    wait_strobe();
    @(negedge clk);
    check("R10 strobe width", conv_start, 0);

    // R4 zoom
    cfg_lp_en = 1'b1;
    cfg_lp_sel = 2'd1;
    wait_strobe();
    pulse_prox();
    measure(n);
    check("R4 zoomed period", n, 4);
    wait_ticks(60);
    wait_strobe();
    measure(n);
    check("R4 period after hold", n, 16);
    pulse_prox();
    wait_ticks(30);
    pulse_prox();
    wait_ticks(30);
    measure(n);
    check("R4 hold renewed", n, 4);
    cfg_lp_en = 1'b0;

    // R5 / R6 reduced state with refresh
    cfg_xlp_en = 1'b1;
    wait_ticks(150);
    n_full = 0;
    n_red = 0;
    for (int s = 0; s < 12; s++) begin
      wait_strobe();
      if (ch_en == 8'hFF) n_full++;
      if (ch_en == 8'h80) n_red++;
    end
    check("R5 reduced masks", n_red, 10);
    check("R6 refresh masks", n_full, 2);

    // R7 proximity restores all channels
    pulse_prox();
    wait_strobe();
    check("R7 mask after prox", ch_en, 8'hFF);
    wait_strobe();
    check("R7 mask stays full", ch_en, 8'hFF);
    cfg_xlp_en = 1'b0;

    // R8 sleep
    wait_strobe();
    cfg_sleep = 1'b1;
    repeat (4) @(negedge clk);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (conv_start) n++;
    end
    check("R8 strobes while asleep", n, 0);
    check("R8 ch_en while asleep", ch_en, 0);

    // R9 wake on ready rising edge
    rdy_line = 1'b1;
    count_to_strobe(n);
    check("R9 first period after wake", n, 4);
    rdy_line = 1'b0;
    measure(n);
    check("R9 awake with sleep bit held", n, 4);
    cfg_sleep = 1'b0;

    // R9 ready edges while awake are ignored
    wait_strobe();
    fork
      count_to_strobe(n);
      begin
        repeat (3) @(negedge clk);
        rdy_line = 1'b1;
        repeat (2) @(negedge clk);
        rdy_line = 1'b0;
      end
    join
    check("R9 ready ignored while awake", n, 4);

    finish_run();
  end
endmodule